// File: doc/BRIEF.md
# Two-Stage Ternary Match Engine

This block searches a small ternary match table in two pipelined stages. The table is split into blocks of entries, and each block carries one short tag. In the first stage the tag key is compared against every block's tag. In the second stage the wide data key is compared only against the entries of blocks whose tag matched, so the wide compare logic in the other blocks stays idle. The tag filter can be switched off for a search, and then every block takes part in the second stage.

Each stored data bit is a value/care pair, so an entry can hold don't-care positions. A global per-bit mask, as wide as one base entry, removes key positions from the second-stage compare. A lookup may span 1, 2, 4 or 8 consecutive base entries. The lowest-numbered matching span wins. The result carries a valid strobe, a hit flag and the index of the first base entry of the winning span. The table contents and the block tags come in on ports from the separate logic that writes them, and they must stay stable while a search is in flight.

Top module: `tcam_hier_search`

## Requirements
- R1: While reset is asserted and until the first search completes, `res_valid` and `res_hit` are 0 and `res_idx` is 0.
- R2: A search presented with `srch_valid` high at rising edge k gives `res_valid` high for exactly the cycle after edge k+1. This happens for a hit and for a miss. In cycles with no search result, `res_valid` is 0.
- R3: A table bit whose care bit is 0 matches either key bit. A table bit whose care bit is 1 matches only an equal key bit.
- R4: A `cfg_gmask` bit of 1 excludes that bit position from the compare in every key slice. The mask has no effect on the tag compare.
- R5: With `srch_filt_en` = 1, only entries of blocks whose tag equals `srch_tag` exactly can match. Entry e lies in block e / 8.
- R6: With `srch_filt_en` = 0, entries in every block can match, whatever the tags are.
- R7: `srch_width` encodes the span: 0 → 1, 1 → 2, 2 → 4, 3 → 8 base entries. Spans are aligned to their own size. Entry g+j of a span starting at g is compared against key bits [16j+15:16j]. A span matches only if all of its entries match.
- R8: On a hit, `res_idx` is the first entry of the winning span, so it is a multiple of the span size.
- R9: When several spans match, the one with the lowest index wins.
- R10: On a miss, `res_valid` is 1, `res_hit` is 0 and `res_idx` is 0.
- R11: Searches issued on consecutive cycles each produce their own result, in issue order, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_valid | input | 1 | A search is presented this cycle |
| srch_filt_en | input | 1 | Enable the first-stage tag filter |
| srch_tag | input | 4 | Tag key for the first stage |
| srch_width | input | 2 | Span code (1/2/4/8 base entries) |
| srch_key | input | 128 | Data key, one 16-bit slice per base entry of a span |
| cfg_gmask | input | 16 | Global mask, 1 excludes the bit position |
| tbl_tag | input | 16 | Block tags, block b at bits [4b+3:4b] |
| tbl_value | input | 512 | Entry values, entry e at bits [16e+15:16e] |
| tbl_care | input | 512 | Entry care bits, same layout as values |
| res_valid | output | 1 | Result strobe, one per search |
| res_hit | output | 1 | The search found a matching span |
| res_idx | output | 5 | Index of the winning span's first entry |

## Verification
The bench builds the block with its default parameters: 4 blocks of 8 entries, 16-bit base entries and spans of up to 8 entries. With these values the widest span covers exactly one block, so the tag filter and the span grouping meet at the block edge. Every width code can reach every aligned group. During the random phases, table values come from a three-bit alphabet with random don't-cares, and tags repeat across blocks. This makes multiple matches, priority conflicts and filter-induced misses common, rather than rare.

// File: rtl/tcam_hs_pkg.sv
package tcam_hs_pkg;

  // span code carried on srch_width: number of base entries = 1 << code
  typedef enum logic [1:0] {
    SPAN_1 = 2'd0,
    SPAN_2 = 2'd1,
    SPAN_4 = 2'd2,
    SPAN_8 = 2'd3
  } span_e;

  localparam int SPAN_CODES = 4;
  localparam int MAX_SPAN   = 1 << (SPAN_CODES - 1);
  localparam int SPAN_W     = $clog2(SPAN_CODES);

  function automatic int span_len(input logic [SPAN_W-1:0] code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/tcam_hs_tag_stage.sv
module tcam_hs_tag_stage
  import tcam_hs_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int TAG_W   = 4,
  parameter int DW      = 16,
  parameter int KEY_W   = DW * MAX_SPAN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_filt_en,
  input  logic [TAG_W-1:0]         in_tag,
  input  logic [SPAN_W-1:0]        in_width,
  input  logic [KEY_W-1:0]         in_key,
  input  logic [DW-1:0]            in_gmask,
  input  logic [NUM_BLK*TAG_W-1:0] tbl_tag,
  output logic                     s1_valid,
  output logic [NUM_BLK-1:0]       s1_blk_en,
  output logic [SPAN_W-1:0]        s1_width,
  output logic [KEY_W-1:0]         s1_key,
  output logic [DW-1:0]            s1_gmask
);

  logic [NUM_BLK-1:0] tag_hit;
  logic [NUM_BLK-1:0] nxt_blk_en;

  // one tag comparator per block
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_tag
    assign tag_hit[b] = (tbl_tag[b*TAG_W +: TAG_W] == in_tag);
  end

  always_comb begin
    nxt_blk_en = in_filt_en ? tag_hit : {NUM_BLK{1'b1}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  // payload registers load only with a search
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_blk_en <= '0;
      s1_width  <= '0;
      s1_key    <= '0;
      s1_gmask  <= '0;
    end else if (in_valid) begin
      s1_blk_en <= nxt_blk_en;
      s1_width  <= in_width;
      s1_key    <= in_key;
      s1_gmask  <= in_gmask;
    end
  end

  // unfiltered search must open every block for the second stage
  assert_filter_off_all_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && !$past(in_filt_en)) |-> (&s1_blk_en)
  );

endmodule

// File: rtl/tcam_hs_row_cmp.sv
module tcam_hs_row_cmp #(
  parameter int DW = 16
) (
  input  logic          en,
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] care,
  input  logic [DW-1:0] key,
  input  logic [DW-1:0] gmask,
  output logic          match
);

  logic [DW-1:0] miss_bits;

  always_comb begin
    miss_bits = care & (value ^ key) & ~gmask;
    match     = en & ~(|miss_bits);
  end

endmodule

// File: rtl/tcam_hs_group_pe.sv
module tcam_hs_group_pe
  import tcam_hs_pkg::*;
#(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SPAN_W-1:0] in_width,
  input  logic [N-1:0]      ent_match,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx
);

  logic [N-1:0]     grp_all [SPAN_CODES];
  logic [N-1:0]     grp_sel;
  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  logic             nxt_valid;
  logic             nxt_hit;
  logic [IDX_W-1:0] nxt_idx;

  // one group-merge network per span code; the match lands on the span start
  for (genvar k = 0; k < SPAN_CODES; k++) begin : g_span
    localparam int W = 1 << k;
    logic [N-1:0] grp;
    always_comb begin
      grp = '0;
      for (int g = 0; g < N / W; g++) begin
        grp[g*W] = &ent_match[g*W +: W];
      end
    end
    assign grp_all[k] = grp;
  end

  always_comb begin
    grp_sel = grp_all[in_width];
  end

  // lowest index wins
  always_comb begin
    win_idx = '0;
    any_hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (grp_sel[i]) begin
        win_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    nxt_valid = in_valid;
    nxt_hit   = in_valid & any_hit;
    nxt_idx   = (in_valid && any_hit) ? win_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= nxt_valid;
      res_hit   <= nxt_hit;
      res_idx   <= nxt_idx;
    end
  end

  assert_idx_aligned_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    res_hit |-> ((res_idx & IDX_W'(span_len($past(in_width)) - 1)) == '0)
  );

  assert_lowest_wins_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    res_hit |-> (($past(grp_sel) & ((N'(1) << res_idx) - N'(1))) == '0)
  );

endmodule

// File: rtl/tcam_hier_search.sv
module tcam_hier_search
  import tcam_hs_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int BLK_ENT = 8,
  parameter int DW      = 16,
  parameter int TAG_W   = 4,
  localparam int N      = NUM_BLK * BLK_ENT,
  localparam int IDX_W  = $clog2(N),
  localparam int KEY_W  = DW * MAX_SPAN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     srch_valid,
  input  logic                     srch_filt_en,
  input  logic [TAG_W-1:0]         srch_tag,
  input  logic [SPAN_W-1:0]        srch_width,
  input  logic [KEY_W-1:0]         srch_key,
  input  logic [DW-1:0]            cfg_gmask,
  input  logic [NUM_BLK*TAG_W-1:0] tbl_tag,
  input  logic [N*DW-1:0]          tbl_value,
  input  logic [N*DW-1:0]          tbl_care,
  output logic                     res_valid,
  output logic                     res_hit,
  output logic [IDX_W-1:0]         res_idx
);

  localparam int LANE_W = $clog2(MAX_SPAN);

  logic               s1_valid;
  logic [NUM_BLK-1:0] s1_blk_en;
  logic [SPAN_W-1:0]  s1_width;
  logic [KEY_W-1:0]   s1_key;
  logic [DW-1:0]      s1_gmask;
  logic [N-1:0]       ent_match;
  logic [LANE_W-1:0]  lane_mask;

  // stage 1: tag compare per block, capture of the search
  tcam_hs_tag_stage #(
    .NUM_BLK (NUM_BLK),
    .TAG_W   (TAG_W),
    .DW      (DW),
    .KEY_W   (KEY_W)
  ) u_tag (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (srch_valid),
    .in_filt_en (srch_filt_en),
    .in_tag     (srch_tag),
    .in_width   (srch_width),
    .in_key     (srch_key),
    .in_gmask   (cfg_gmask),
    .tbl_tag    (tbl_tag),
    .s1_valid   (s1_valid),
    .s1_blk_en  (s1_blk_en),
    .s1_width   (s1_width),
    .s1_key     (s1_key),
    .s1_gmask   (s1_gmask)
  );

  always_comb begin
    lane_mask = LANE_W'(span_len(s1_width) - 1);
  end

  // stage 2: wide compare, gated per block by the stage-1 result
  for (genvar e = 0; e < N; e++) begin : g_ent
    localparam int BLK  = e / BLK_ENT;
    localparam int LANE = e % MAX_SPAN;
    logic [LANE_W-1:0] slice_sel;
    logic [DW-1:0]     key_slice;
    logic              row_en;

    always_comb begin
      slice_sel = LANE_W'(LANE) & lane_mask;
      key_slice = s1_key[slice_sel*DW +: DW];
      row_en    = s1_valid & s1_blk_en[BLK];
    end

    tcam_hs_row_cmp #(
      .DW (DW)
    ) u_row (
      .en    (row_en),
      .value (tbl_value[e*DW +: DW]),
      .care  (tbl_care[e*DW +: DW]),
      .key   (key_slice),
      .gmask (s1_gmask),
      .match (ent_match[e])
    );
  end

  tcam_hs_group_pe #(
    .N     (N),
    .IDX_W (IDX_W)
  ) u_pe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s1_valid),
    .in_width  (s1_width),
    .ent_match (ent_match),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_idx   (res_idx)
  );

  assert_two_cycle_result_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    res_valid == $past(srch_valid, 2)
  );

  // a winner must sit in a block the first stage opened
  assert_winner_in_open_block_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    res_hit |-> (|(($past(s1_blk_en) >> (res_idx / BLK_ENT)) & NUM_BLK'(1)))
  );

  assert_miss_idx_zero_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == '0)
  );

endmodule

// File: tb/tcam_hier_search_tb.sv
module tcam_hier_search_tb;

  localparam int NB = 4;
  localparam int BE = 8;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int N  = NB * BE;
  localparam int IW = 5;
  localparam int KW = DW * 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic           srch_valid;
  logic           srch_filt_en;
  logic [TW-1:0]  srch_tag;
  logic [1:0]     srch_width;
  logic [KW-1:0]  srch_key;
  logic [DW-1:0]  cfg_gmask;
  logic [NB*TW-1:0] tbl_tag;
  logic [N*DW-1:0]  tbl_value;
  logic [N*DW-1:0]  tbl_care;
  logic           res_valid;
  logic           res_hit;
  logic [IW-1:0]  res_idx;

  logic [DW-1:0] t_val  [N];
  logic [DW-1:0] t_care [N];
  logic [TW-1:0] t_tag  [NB];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tbl_value[i*DW +: DW] = t_val[i];
      tbl_care[i*DW +: DW]  = t_care[i];
    end
    for (int b = 0; b < NB; b++) tbl_tag[b*TW +: TW] = t_tag[b];
  end

  tcam_hier_search u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .srch_valid   (srch_valid),
    .srch_filt_en (srch_filt_en),
    .srch_tag     (srch_tag),
    .srch_width   (srch_width),
    .srch_key     (srch_key),
    .cfg_gmask    (cfg_gmask),
    .tbl_tag      (tbl_tag),
    .tbl_value    (tbl_value),
    .tbl_care     (tbl_care),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_idx      (res_idx)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic          e_v [2];
  logic          e_h [2];
  logic [IW-1:0] e_i [2];
  string         e_r [2];

  function automatic void ref_search(input logic [TW-1:0] tg, input logic filt,
                                     input logic [1:0] wc, input logic [KW-1:0] key,
                                     input logic [DW-1:0] msk,
                                     output logic hit, output logic [IW-1:0] idx);
    int w;
    w = 1 << wc;
    hit = 1'b0;
    idx = '0;
    for (int g = 0; g < N; g += w) begin
      logic ok;
      ok = 1'b1;
      if (filt && t_tag[g / BE] != tg) ok = 1'b0;
      for (int j = 0; j < w; j++)
        for (int b = 0; b < DW; b++)
          if (t_care[g+j][b] && !msk[b] && (t_val[g+j][b] != key[j*DW + b])) ok = 1'b0;
      if (ok && !hit) begin
        hit = 1'b1;
        idx = IW'(g);
      end
    end
  endfunction

  function automatic logic [KW-1:0] mk_key(input int g, input logic [1:0] wc);
    logic [KW-1:0] k;
    k = '0;
    for (int j = 0; j < (1 << wc); j++) k[j*DW +: DW] = t_val[g+j];
    return k;
  endfunction

  task automatic check_out(input logic v, input logic h, input logic [IW-1:0] ix, input string req);
    checks++;
    if (res_valid !== v || res_hit !== h || res_idx !== ix) begin
      fails++;
      $display("FAIL %s: valid=%0b hit=%0b idx=%0d expected valid=%0b hit=%0b idx=%0d",
               req, res_valid, res_hit, res_idx, v, h, ix);
    end
  endtask

  task automatic cyc(input logic v, input logic filt, input logic [TW-1:0] tg,
                     input logic [1:0] wc, input logic [KW-1:0] key,
                     input logic [DW-1:0] msk, input string req);
    logic h;
    logic [IW-1:0] ix;
    @(negedge clk);
    check_out(e_v[1], e_h[1], e_i[1], e_r[1]);
    e_v[1] = e_v[0]; e_h[1] = e_h[0]; e_i[1] = e_i[0]; e_r[1] = e_r[0];
    if (v) ref_search(tg, filt, wc, key, msk, h, ix);
    else begin h = 1'b0; ix = '0; end
    e_v[0] = v; e_h[0] = h; e_i[0] = ix; e_r[0] = req;
    srch_valid   = v;
    srch_filt_en = filt;
    srch_tag     = tg;
    srch_width   = wc;
    srch_key     = key;
    cfg_gmask    = msk;
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 1'b0, '0, 2'd0, '0, '0, req);
  endtask

  task automatic flush();
    idle("R2");
    idle("R2");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] k;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin e_v[i] = 0; e_h[i] = 0; e_i[i] = '0; e_r[i] = "R1"; end
    for (int e = 0; e < N; e++) begin t_val[e] = 16'hC000 | DW'(e); t_care[e] = 16'hFFFF; end
    for (int b = 0; b < NB; b++) t_tag[b] = TW'(8 + b);
    rst_n = 1'b0;
    srch_valid = 0; srch_filt_en = 0; srch_tag = '0; srch_width = '0; srch_key = '0; cfg_gmask = '0;
    repeat (3) @(negedge clk);
    check_out(1'b0, 1'b0, '0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_out(1'b0, 1'b0, '0, "R1");

    // R3 exact and don't-care matching
    cyc(1, 0, '0, 2'd0, KW'(t_val[9]), '0, "R3");
    t_care[12] = 16'h00FF;
    flush();
    cyc(1, 0, '0, 2'd0, KW'({8'h37, t_val[12][7:0]}), '0, "R3");
    cyc(1, 0, '0, 2'd0, KW'({8'h37, 8'h0D}), '0, "R3");
    // R2 single pulse, then idle result
    idle("R2");
    idle("R2");
    // R4 mask excludes bits, tag compare unaffected
    cyc(1, 0, '0, 2'd0, KW'(16'h0003), 16'hFFF0, "R4");
    cyc(1, 1, TW'(10), 2'd0, KW'(16'h0003), 16'hFFF0, "R4");
    // R5 filter blocks a real data match, R10 miss outputs
    cyc(1, 1, TW'(8), 2'd0, KW'(t_val[9]), '0, "R5");
    cyc(1, 1, TW'(9), 2'd0, KW'(t_val[9]), '0, "R5");
    cyc(1, 1, TW'(8), 2'd0, KW'(t_val[9]), '0, "R10");
    // R6 filter off ignores tags
    cyc(1, 0, TW'(8), 2'd0, KW'(t_val[9]), '0, "R6");
    // R7/R8 spans
    cyc(1, 0, '0, 2'd1, mk_key(10, 2'd1), '0, "R7");
    k = mk_key(10, 2'd1); k[DW +: DW] = 16'h1234;
    cyc(1, 0, '0, 2'd1, k, '0, "R7");
    cyc(1, 0, '0, 2'd2, mk_key(28, 2'd2), '0, "R8");
    cyc(1, 0, '0, 2'd3, mk_key(16, 2'd3), '0, "R8");
    cyc(1, 0, '0, 2'd3, mk_key(24, 2'd3), '0, "R7");
    // key sliced off a misaligned start must miss at width 2
    cyc(1, 0, '0, 2'd1, mk_key(11, 2'd1), '0, "R7");
    flush();
    // R9 priority among duplicates
    t_val[20] = t_val[6];
    t_val[21] = t_val[7];
    flush();
    cyc(1, 0, '0, 2'd0, KW'(t_val[6]), '0, "R9");
    cyc(1, 1, TW'(10), 2'd0, KW'(t_val[6]), '0, "R9");
    cyc(1, 0, '0, 2'd1, mk_key(6, 2'd1), '0, "R9");
    flush();

    // R11 back-to-back random searches over small-alphabet tables
    for (int round = 0; round < 4; round++) begin
      for (int e = 0; e < N; e++) begin
        t_val[e]  = DW'($urandom_range(0, 7));
        t_care[e] = {13'h1FFF, 3'($urandom)};
      end
      for (int b = 0; b < NB; b++) t_tag[b] = TW'($urandom_range(0, 3));
      for (int n = 0; n < 150; n++) begin
        logic [1:0] wc;
        int g;
        logic [TW-1:0] tg;
        logic [DW-1:0] msk;
        wc = 2'($urandom_range(0, 3));
        g  = $urandom_range(0, (N >> wc) - 1) << wc;
        k  = mk_key(g, wc);
        if ($urandom_range(0, 3) == 0) k = k ^ KW'($urandom_range(0, 7));
        tg  = ($urandom_range(0, 1) == 1) ? t_tag[g / BE] : TW'($urandom_range(0, 3));
        msk = ($urandom_range(0, 2) == 0) ? DW'($urandom) : '0;
        if ($urandom_range(0, 9) == 0) idle("R11");
        else cyc(1, 1'($urandom_range(0, 1)), tg, wc, k, msk, "R11");
      end
      flush();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule